// File: doc/BRIEF.md
# Playback Sample Buffer with Underrun Policy

This block sits between a host that writes audio samples and a converter that consumes one stereo sample per sample period. A sample is a pair of 16-bit two's-complement values, left and right, and each buffer entry holds both halves together. The buffer is 16 entries deep. In the buffered modes the block asks the host for data for as long as any entry is free, so the buffer is kept topped up. Each sample-period strobe pops the oldest entry into the registered converter outputs.

When a strobe finds the buffer empty, a control bit selects what the converter receives. With the bit clear it keeps receiving the last valid sample. With the bit set it receives midscale, which is 0x0000 on both channels. Two sticky flags record events for software. One records a strobe that found the buffer empty. The other records a host write that was dropped because the buffer was full. Each flag clears through its own clear input.

In direct mode the buffer is bypassed. A host write goes straight to the converter outputs and the strobe is ignored.

Top module: `playback_buffer`

## Requirements
- R1: In a buffered mode, `host_req_o` is 1 while fewer than 16 entries are stored and 0 once 16 are stored. It follows the occupancy from the cycle after the push or pop that changed it.
- R2: Entries leave in the order they were pushed. Each entry's left and right values come out together.
- R3: In a buffered mode, a cycle with `tick_i`=1 and a non-empty buffer loads the oldest entry onto `dac_left_o`/`dac_right_o` at that clock edge. In a cycle with neither a push nor a tick, the outputs do not change.
- R4: When `tick_i`=1 finds the buffer empty and `zero_fill_i`=0, the outputs keep the last valid sample.
- R5: When `tick_i`=1 finds the buffer empty and `zero_fill_i`=1, both outputs become midscale, 16'h0000.
- R6: A tick that finds the buffer empty in a buffered mode sets `underflow_o` from the next cycle on. The flag stays set until a cycle with `clr_underflow_i`=1. If a set and a clear fall in the same cycle, the set wins.
- R7: A push while 16 entries are stored, with no tick in the same cycle, is dropped and sets `overrun_o`. `clr_overrun_i`=1 clears the flag.
- R8: A push and a pop in the same cycle leave the occupancy unchanged. A push to a full buffer in a cycle that also pops is accepted.
- R9: With `mode_i`=2'b00 (direct), a push appears on the outputs at the next edge. Ticks have no effect and `host_req_o` is 1. The buffer is emptied and neither flag is set. The values 2'b01, 2'b10 and 2'b11 all select buffered operation.
- R10: After reset the outputs are 0, both flags are 0, the buffer is empty and `host_req_o` is 1 in a buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 selects direct mode; any other value selects buffered mode |
| zero_fill_i | input | 1 | Underrun policy: 0 holds the last sample, 1 outputs midscale |
| push_i | input | 1 | Host writes one stereo sample |
| push_left_i | input | 16 | Left value of the pushed sample |
| push_right_i | input | 16 | Right value of the pushed sample |
| host_req_o | output | 1 | Request for more data from the host |
| tick_i | input | 1 | Sample-period strobe from the converter side |
| dac_left_o | output | 16 | Left value sent to the converter |
| dac_right_o | output | 16 | Right value sent to the converter |
| underflow_o | output | 1 | Sticky flag: a tick found the buffer empty |
| overrun_o | output | 1 | Sticky flag: a push was dropped because the buffer was full |
| clr_underflow_i | input | 1 | Clears `underflow_o` |
| clr_overrun_i | input | 1 | Clears `overrun_o` |

## Verification
The properties assume that every input is synchronous to `clk` and is held stable across a clock edge. They also assume that the host treats a low `host_req_o` in a buffered mode as meaning the buffer is full. The stimulus changes inputs only on the falling edge and keeps each value for a whole cycle. It changes `mode_i` only in cycles with no push and no tick, so that no property sees a mode switch in the same cycle as a transfer.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
    localparam int unsigned SAMPLE_W = 16;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_BUF_A  = 2'b01,
        MODE_BUF_B  = 2'b10,
        MODE_BUF_C  = 2'b11
    } pb_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } frame_t;

    localparam int unsigned FRAME_W = $bits(frame_t);
    localparam frame_t MIDSCALE = '{left: '0, right: '0};
endpackage

// File: rtl/pbuf_ptr.sv
module pbuf_ptr #(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          empty,
    output logic          full,
    output logic          pop_ok,
    output logic          overrun_evt,
    output logic          underrun_evt
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic    push_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty        = (st_q.cnt == '0);
        full         = (st_q.cnt == CW'(DEPTH));
        pop_ok       = pop & ~empty;
        push_ok      = push & (~full | pop_ok);
        underrun_evt = pop & empty;
        overrun_evt  = push & ~push_ok;
        wr_en        = push_ok;
        wr_ptr       = st_q.wr;
        rd_ptr       = st_q.rd;

        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = bump(st_q.wr);
            if (pop_ok)  st_d.rd = bump(st_q.rd);
            unique case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pbuf_store.sv
module pbuf_store #(
    parameter  int unsigned DEPTH = 16,
    parameter  int unsigned W     = 32,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pbuf_out.sv
module pbuf_out
    import pbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bypass,
    input  logic   push,
    input  frame_t push_frame,
    input  logic   pop_ok,
    input  frame_t head_frame,
    input  logic   underrun_evt,
    input  logic   overrun_evt,
    input  logic   zero_fill,
    input  logic   clr_uf,
    input  logic   clr_ov,
    output frame_t dac_frame,
    output logic   uf_flag,
    output logic   ov_flag
);
    typedef struct packed {
        frame_t smp;
        logic   uf;
        logic   ov;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bypass) begin
            if (push) st_d.smp = push_frame;
        end else if (pop_ok) begin
            st_d.smp = head_frame;
        end else if (underrun_evt && zero_fill) begin
            st_d.smp = MIDSCALE;
        end
        st_d.uf = (st_q.uf & ~clr_uf) | underrun_evt;
        st_d.ov = (st_q.ov & ~clr_ov) | overrun_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{smp: MIDSCALE, uf: 1'b0, ov: 1'b0};
        else        st_q <= st_d;
    end

    assign dac_frame = st_q.smp;
    assign uf_flag   = st_q.uf;
    assign ov_flag   = st_q.ov;
endmodule

// File: rtl/playback_buffer.sv
module playback_buffer
    import pbuf_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                zero_fill_i,
    input  logic                push_i,
    input  logic [SAMPLE_W-1:0] push_left_i,
    input  logic [SAMPLE_W-1:0] push_right_i,
    output logic                host_req_o,
    input  logic                tick_i,
    output logic [SAMPLE_W-1:0] dac_left_o,
    output logic [SAMPLE_W-1:0] dac_right_o,
    output logic                underflow_o,
    output logic                overrun_o,
    input  logic                clr_underflow_i,
    input  logic                clr_overrun_i
);
    logic          bypass;
    logic          fifo_push, fifo_pop;
    logic          wr_en, fifo_empty, fifo_full, pop_ok;
    logic          ov_evt, ur_evt;
    logic [AW-1:0] wr_ptr, rd_ptr;
    frame_t        push_frame, head_frame, dac_frame;

    assign bypass     = (pb_mode_e'(mode_i) == MODE_DIRECT);
    assign fifo_push  = push_i & ~bypass;
    assign fifo_pop   = tick_i & ~bypass;
    assign push_frame = '{left: push_left_i, right: push_right_i};

    pbuf_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (bypass),
        .push        (fifo_push),
        .pop         (fifo_pop),
        .wr_en       (wr_en),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .empty       (fifo_empty),
        .full        (fifo_full),
        .pop_ok      (pop_ok),
        .overrun_evt (ov_evt),
        .underrun_evt(ur_evt)
    );

    pbuf_store #(.DEPTH(DEPTH), .W(FRAME_W)) u_store (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wr_ptr),
        .wdata(push_frame),
        .raddr(rd_ptr),
        .rdata(head_frame)
    );

    pbuf_out u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .bypass      (bypass),
        .push        (push_i),
        .push_frame  (push_frame),
        .pop_ok      (pop_ok),
        .head_frame  (head_frame),
        .underrun_evt(ur_evt),
        .overrun_evt (ov_evt),
        .zero_fill   (zero_fill_i),
        .clr_uf      (clr_underflow_i),
        .clr_ov      (clr_overrun_i),
        .dac_frame   (dac_frame),
        .uf_flag     (underflow_o),
        .ov_flag     (overrun_o)
    );

    assign host_req_o  = bypass | ~fifo_full;
    assign dac_left_o  = dac_frame.left;
    assign dac_right_o = dac_frame.right;
endmodule

// File: rtl/pbuf_checker.sv
module pbuf_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bypass,
    input logic         push,
    input logic         tick,
    input logic         zero_fill,
    input logic         clr_uf,
    input logic         clr_ov,
    input logic         fifo_empty,
    input logic         host_req,
    input logic [W-1:0] push_l,
    input logic [W-1:0] push_r,
    input logic [W-1:0] dac_l,
    input logic [W-1:0] dac_r,
    input logic         underflow,
    input logic         overrun
);
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !push && !tick) |=> ($stable(dac_l) && $stable(dac_r))); // R3

    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && tick && fifo_empty && !zero_fill) |=> ($stable(dac_l) && $stable(dac_r))); // R4

    AST_UNDERRUN_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && tick && fifo_empty && zero_fill) |=> (dac_l == '0 && dac_r == '0)); // R5

    AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && tick && fifo_empty) |=> underflow); // R6

    AST_UNDERFLOW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_uf && !(!bypass && tick && fifo_empty)) |=> !underflow); // R6

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && push && !host_req && !tick) |=> overrun); // R7

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && push) |=> (dac_l == $past(push_l) && dac_r == $past(push_r))); // R9

    AST_DIRECT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !underflow && !overrun) |=> (!underflow && !overrun)); // R9
endmodule

bind playback_buffer pbuf_checker #(.W(pbuf_pkg::SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bypass    (bypass),
    .push      (push_i),
    .tick      (tick_i),
    .zero_fill (zero_fill_i),
    .clr_uf    (clr_underflow_i),
    .clr_ov    (clr_overrun_i),
    .fifo_empty(fifo_empty),
    .host_req  (host_req_o),
    .push_l    (push_left_i),
    .push_r    (push_right_i),
    .dac_l     (dac_left_o),
    .dac_r     (dac_right_o),
    .underflow (underflow_o),
    .overrun   (overrun_o)
);

// File: tb/tb_playback_buffer.sv
module tb_playback_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic        zf = 1'b0;
    logic        push = 1'b0;
    logic [15:0] pl = '0, pr = '0;
    logic        tick = 1'b0;
    logic        clr_uf = 1'b0, clr_ov = 1'b0;
    logic        req, uf, ov;
    logic [15:0] dl, dr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    playback_buffer dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .zero_fill_i(zf),
        .push_i(push), .push_left_i(pl), .push_right_i(pr),
        .host_req_o(req), .tick_i(tick),
        .dac_left_o(dl), .dac_right_o(dr),
        .underflow_o(uf), .overrun_o(ov),
        .clr_underflow_i(clr_uf), .clr_overrun_i(clr_ov)
    );

    // push, left, right, tick, zero_fill, expected left, expected right, expected request
    typedef struct packed {
        logic        p;
        logic [15:0] l;
        logic [15:0] r;
        logic        t;
        logic        z;
        logic [15:0] el;
        logic [15:0] er;
        logic        ereq;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 16'h1111, 16'hA111, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},
        '{1'b1, 16'h2222, 16'hB222, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h1111, 16'hA111, 1'b1},
        '{1'b1, 16'h3333, 16'hC333, 1'b1, 1'b0, 16'h2222, 16'hB222, 1'b1},
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h3333, 16'hC333, 1'b1},
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h3333, 16'hC333, 1'b1},
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b1},
        '{1'b1, 16'h4444, 16'hD444, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b1},
        '{1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 16'h4444, 16'hD444, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        push = 1'b0; tick = 1'b0; clr_uf = 1'b0; clr_ov = 1'b0;
        pl = '0; pr = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R10 reset state
        check("R10 dac", {dl, dr}, 32'h0);
        check("R10 flags", {30'h0, uf, ov}, 32'h0);
        check("R10 req", {31'h0, req}, 32'h1);

        // Vector table: R2 R3 R4 R5 R8
        for (int i = 0; i < NVEC; i++) begin
            push = VEC[i].p; pl = VEC[i].l; pr = VEC[i].r;
            tick = VEC[i].t; zf = VEC[i].z;
            cyc();
            check($sformatf("R3 vec%0d dac", i), {dl, dr}, {VEC[i].el, VEC[i].er});
            check($sformatf("R1 vec%0d req", i), {31'h0, req}, {31'h0, VEC[i].ereq});
            idle();
        end
        zf = 1'b0;
        check("R6 flag after underruns", {31'h0, uf}, 32'h1);

        clr_uf = 1'b1; cyc(); idle();
        check("R6 clear", {31'h0, uf}, 32'h0);

        // Fill to full: R1
        for (int i = 0; i < 16; i++) begin
            push = 1'b1; pl = 16'h0100 + 16'(i); pr = 16'h0200 + 16'(i);
            cyc(); idle();
            if (i == 14) check("R1 req at 15", {31'h0, req}, 32'h1);
        end
        check("R1 req at 16", {31'h0, req}, 32'h0);

        // Push while full, no tick: R7
        push = 1'b1; pl = 16'hDEAD; pr = 16'hDEAD; cyc(); idle();
        check("R7 overrun set", {31'h0, ov}, 32'h1);
        check("R7 dac untouched", {dl, dr}, 32'h4444D444);

        // Push and pop together at full: R8
        push = 1'b1; tick = 1'b1; pl = 16'h0E0E; pr = 16'hE0E0; cyc(); idle();
        check("R8 pop head", {dl, dr}, 32'h01000200);
        check("R8 still full", {31'h0, req}, 32'h0);

        // Drain: R2 order, R1 request returns
        for (int i = 1; i < 17; i++) begin
            tick = 1'b1; cyc(); idle();
            if (i < 16) check($sformatf("R2 drain %0d", i), {dl, dr},
                              {16'h0100 + 16'(i), 16'h0200 + 16'(i)});
            else        check("R2 drain last", {dl, dr}, 32'h0E0EE0E0);
            if (i == 1) check("R1 req after pop", {31'h0, req}, 32'h1);
        end

        // Empty tick, hold: R4 R6
        tick = 1'b1; cyc(); idle();
        check("R4 hold", {dl, dr}, 32'h0E0EE0E0);
        check("R6 set", {31'h0, uf}, 32'h1);

        // Clear and set in same cycle: R6 set wins
        clr_uf = 1'b1; tick = 1'b1; cyc(); idle();
        check("R6 set wins", {31'h0, uf}, 32'h1);

        clr_ov = 1'b1; cyc(); idle();
        check("R7 clear", {31'h0, ov}, 32'h0);

        // Midscale: R5
        zf = 1'b1; tick = 1'b1; cyc(); idle(); zf = 1'b0;
        check("R5 midscale", {dl, dr}, 32'h0);

        // Direct mode: R9
        mode = 2'b00; clr_uf = 1'b1; cyc(); idle();
        check("R9 req", {31'h0, req}, 32'h1);
        push = 1'b1; pl = 16'h7777; pr = 16'h8888; cyc(); idle();
        check("R9 pass", {dl, dr}, 32'h77778888);
        tick = 1'b1; cyc(); idle();
        check("R9 tick ignored", {dl, dr}, 32'h77778888);
        check("R9 no flags", {30'h0, uf, ov}, 32'h0);
        mode = 2'b10; cyc();
        // Buffer was emptied by direct mode: tick underruns and holds
        tick = 1'b1; cyc(); idle();
        check("R9 flushed", {31'h0, uf}, 32'h1);
        check("R4 hold after direct", {dl, dr}, 32'h77778888);

        // Reset again: R10
        rst_n = 1'b0; cyc();
        check("R10 mid reset", {dl, dr, 14'h0, uf, ov}, 48'h0);
        rst_n = 1'b1; cyc();
        check("R10 req", {31'h0, req}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule